// File: doc/BRIEF.md
# Free-Running Compare Event Unit

This block pairs a 32-bit counter with a bank of eight compare channels. The counter never stops and never reloads. It steps by one on every clock and rolls from all-ones back to zero, so the same count can serve as a timebase and as an event timer. To schedule an event, software reads the count, adds a delta in 32-bit unsigned arithmetic (wrapping past all-ones) and writes the sum into a compare channel. When the counter reaches that value the channel fires once. This raises a compare interrupt that is separate from the counter's wrap interrupt.

Each channel is a three-state machine. CH_IDLE is the state after reset, before any write; it never fires. CH_ARMED is entered from any state when the channel's compare register is written (transition "arm"). CH_SPENT is entered from CH_ARMED when the counter takes the compare value while the channel is enabled (transition "fire"). A disabled channel in CH_ARMED ignores matches and stays armed (transition "hold"). CH_SPENT returns to CH_ARMED only through a new compare write ("re-arm"). A compare write on the same edge as a match takes priority: the channel re-arms and does not fire.

Top module: `cmp_event_unit`

## Requirements
- R1: While reset is held, the count, channel enable, hit status and armed status registers all read 0, and evt_hit, cmp_irq and wrap_irq are low.
- R2: The count at address 0x00 grows by exactly one per clock. A write to 0x00 loads the written value, and counting resumes from it on the next clock.
- R3: wrap_irq is high for exactly one cycle: the cycle in which the count reads 0 after stepping up from 0xFFFFFFFF. A load never raises it.
- R4: Compare register i is at address 0x60 + 4*i (i = 0..7) and reads back the last value written.
- R5: An armed channel i whose enable bit is set fires when the count becomes equal to its compare value, including targets reached by wrapping past 0xFFFFFFFF. evt_hit[i] and cmp_irq are high for exactly that one cycle, the cycle in which the count equals the compare value. The enable bit is bit i of address 0x04.
- R6: After firing, a channel stays silent on later passes of the count through its value until its compare register is written again.
- R7: Writing a compare register re-arms the channel even after it has fired. A channel whose compare register has never been written since reset never fires.
- R8: A match on an armed channel whose enable bit is clear is ignored, and the channel stays armed. Once enabled, it fires on the next match.
- R9: Address 0x08 holds one sticky hit flag per channel (bit i for channel i), set on a fire. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: Address 0x0C is read-only, and its bit i is 1 exactly while channel i is in CH_ARMED.
- R11: Channels with equal compare values fire in the same cycle. cmp_irq is high in every cycle where any evt_hit bit is high, and low otherwise.
- R12: A count load that sets the count equal to an armed, enabled channel's value fires that channel in the cycle after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_hit | output | 8 | Per-channel one-cycle fire pulse |
| cmp_irq | output | 1 | Compare interrupt, OR of evt_hit |
| wrap_irq | output | 1 | Counter wrap interrupt pulse |

## Verification
A table of cases loads a start count and places a target a given delta ahead on one channel. The cases cover deltas of one and of several hundred, targets that lie past the wrap point, and a target exactly on 0xFFFFFFFF and on 0. Together they separate an off-by-one fire cycle, a comparison against the wrong counter value and a wrap that is mishandled. Directed passes then replay the count over a spent target, a disabled target, a never-written channel, two equal targets and a target reached by a load. These separate one-shot behaviour, enable gating and the status clear rules from a unit that simply compares on every pass.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

    // Per-channel compare state
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_SPENT = 2'd2
    } ch_state_e;

    // Register byte addresses; compare bank starts at 0x60, one word apart
    localparam int ADR_COUNT    = 'h00;
    localparam int ADR_CH_EN    = 'h04;
    localparam int ADR_HIT      = 'h08;
    localparam int ADR_ARMED    = 'h0C;
    localparam int ADR_CMP_BASE = 'h60;
    localparam int CMP_STRIDE   = 4;

endpackage

// File: rtl/cmp_evt_counter.sv
module cmp_evt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             wrap_q
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic wrap_d;

    // Next count is visible to the compare channels on the same edge
    always_comb begin
        cnt_d  = ld ? ld_val : (cnt_q + CNT_ONE);
        wrap_d = !ld && (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            wrap_q <= wrap_d;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R2
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt_q == $past(ld_val))); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (cnt_q == '0)); // R3
    AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |=> !wrap_q); // R3

endmodule

// File: rtl/cmp_evt_channel.sv
module cmp_evt_channel
    import cmp_evt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             armed,
    output logic             fire_q
);
    ch_state_e state_q, state_d;
    logic      hit_now;
    logic      fire_d;

    // Match when the counter takes the compare value on this edge
    always_comb begin
        hit_now = (cnt_d == cmp_q);
    end

    // Next-state logic; a compare write outranks a match
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (wr) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (wr)                 state_d = CH_ARMED;
                else if (en && hit_now) state_d = CH_SPENT;
            end
            CH_SPENT: begin
                if (wr) state_d = CH_ARMED;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        fire_d = (state_q == CH_ARMED) && !wr && en && hit_now;
        armed  = (state_q == CH_ARMED);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Output and compare-value registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
            cmp_q  <= '0;
        end else begin
            fire_q <= fire_d;
            if (wr) cmp_q <= wdata;
        end
    end

    AST_FIRE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> (cnt_q == cmp_q)); // R5
    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q); // R5
    AST_SPENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_SPENT && !wr) |=> !fire_q); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !wr) |=> !fire_q); // R7
    AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (state_q == CH_ARMED)); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !fire_q); // R8
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARMED && !en) |=> (state_q == CH_ARMED)); // R8

endmodule

// File: rtl/cmp_evt_regs.sv
module cmp_evt_regs
    import cmp_evt_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic [NUM_CH-1:0]            wr_bits,
    input  logic [CNT_W-1:0]             cnt_q,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_vals,
    input  logic [NUM_CH-1:0]            armed,
    input  logic [NUM_CH-1:0]            fire,
    output logic [CNT_W-1:0]             bus_rdata,
    output logic                         cnt_ld,
    output logic [NUM_CH-1:0]            cmp_wr,
    output logic [NUM_CH-1:0]            ch_en
);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(ADR_COUNT);
    localparam logic [ADDR_W-1:0] A_CH_EN = ADDR_W'(ADR_CH_EN);
    localparam logic [ADDR_W-1:0] A_HIT   = ADDR_W'(ADR_HIT);
    localparam logic [ADDR_W-1:0] A_ARMED = ADDR_W'(ADR_ARMED);

    logic              sel_cnt, sel_en, sel_hit, sel_arm;
    logic [NUM_CH-1:0] sel_cmp;
    logic [NUM_CH-1:0] ch_en_q;
    logic [NUM_CH-1:0] hit_q, hit_d, clr_mask;

    always_comb begin
        sel_cnt = (bus_addr == A_COUNT);
        sel_en  = (bus_addr == A_CH_EN);
        sel_hit = (bus_addr == A_HIT);
        sel_arm = (bus_addr == A_ARMED);
    end

    generate
        for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_cmp_dec
            localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(ADR_CMP_BASE + CMP_STRIDE * gi);
            assign sel_cmp[gi] = (bus_addr == A_CMP);
            assign cmp_wr[gi]  = bus_wr && sel_cmp[gi];
        end
    endgenerate

    always_comb begin
        cnt_ld   = bus_wr && sel_cnt;
        clr_mask = (bus_wr && sel_hit) ? wr_bits : '0;
        // A fire in the same cycle as a clear keeps the flag set
        hit_d    = (hit_q & ~clr_mask) | fire;
        ch_en    = ch_en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_en_q <= '0;
            hit_q   <= '0;
        end else begin
            if (bus_wr && sel_en) ch_en_q <= wr_bits;
            hit_q <= hit_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_cnt) bus_rdata = cnt_q;
        if (sel_en)  bus_rdata = CNT_W'(ch_en_q);
        if (sel_hit) bus_rdata = CNT_W'(hit_q);
        if (sel_arm) bus_rdata = CNT_W'(armed);
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_cmp[i]) bus_rdata = cmp_vals[i];
        end
    end

    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((hit_q & $past(hit_q & ~clr_mask)) == $past(hit_q & ~clr_mask))); // R9
    AST_HIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> ((hit_q & $past(fire)) == $past(fire))); // R9

endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
    import cmp_evt_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] evt_hit,
    output logic              cmp_irq,
    output logic              wrap_irq
);
    logic [CNT_W-1:0]             cnt_q, cnt_d;
    logic                         cnt_ld;
    logic [NUM_CH-1:0]            cmp_wr, ch_en, armed, fire;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_vals;

    cmp_evt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (cnt_ld),
        .ld_val (bus_wdata),
        .cnt_q  (cnt_q),
        .cnt_d  (cnt_d),
        .wrap_q (wrap_irq)
    );

    generate
        for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
            cmp_evt_channel #(.CNT_W(CNT_W)) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr     (cmp_wr[gc]),
                .wdata  (bus_wdata),
                .en     (ch_en[gc]),
                .cnt_d  (cnt_d),
                .cnt_q  (cnt_q),
                .cmp_q  (cmp_vals[gc]),
                .armed  (armed[gc]),
                .fire_q (fire[gc])
            );
        end
    endgenerate

    cmp_evt_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .wr_bits   (bus_wdata[NUM_CH-1:0]),
        .cnt_q     (cnt_q),
        .cmp_vals  (cmp_vals),
        .armed     (armed),
        .fire      (fire),
        .bus_rdata (bus_rdata),
        .cnt_ld    (cnt_ld),
        .cmp_wr    (cmp_wr),
        .ch_en     (ch_en)
    );

    always_comb begin
        evt_hit = fire;
        cmp_irq = |fire;
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0) |=> !cmp_irq); // R11

endmodule

// File: tb/cmp_event_unit_tb_top.sv
module cmp_event_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_hit;
    logic        cmp_irq, wrap_irq;

    always #5 clk = ~clk;

    cmp_event_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_hit(evt_hit),
        .cmp_irq(cmp_irq), .wrap_irq(wrap_irq)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;
    int hit_cnt, hit_pos, wrap_err, irq_err;
    logic [7:0] hit_val;
    logic [31:0] rv;

    // {channel, start count, delta}
    localparam logic [66:0] VEC [6] = '{
        {3'd0, 32'd100,        32'd10},
        {3'd3, 32'hFFFF_FFF8,  32'h10},
        {3'd7, 32'h0000_1234,  32'd1},
        {3'd5, 32'hFFFF_FFFE,  32'd1},
        {3'd2, 32'hFFFF_FFFF,  32'd1},
        {3'd6, 32'd0,          32'd200}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Must be entered right at a negedge (after wr); sample k is k edges after the last write
    task automatic watch(input int n, input logic [31:0] start);
        hit_cnt = 0; hit_pos = -1; wrap_err = 0; irq_err = 0; hit_val = '0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            #1;
            if (evt_hit != 8'h00) begin hit_cnt++; hit_pos = k; hit_val = evt_hit; end
            if (wrap_irq != ((start + 32'(k)) == 32'd0)) wrap_err++;
            if (cmp_irq != (evt_hit != 8'h00)) irq_err++;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(8'h00, rv); chk(rv == 0, "R1 count", rv, 0);
        rd(8'h04, rv); chk(rv == 0, "R1 enable", rv, 0);
        rd(8'h08, rv); chk(rv == 0, "R1 hit", rv, 0);
        rd(8'h0C, rv); chk(rv == 0, "R1 armed", rv, 0);
        chk(evt_hit == 0 && !cmp_irq && !wrap_irq, "R1 outputs", {22'd0, wrap_irq, cmp_irq, evt_hit}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: never-written channels stay silent as count passes their reset value 0
        wr(8'h04, 32'hFF);
        wr(8'h00, 32'hFFFF_FFFD);
        watch(6, 32'hFFFF_FFFD);
        chk(hit_cnt == 0, "R7 idle silent", hit_cnt, 0);
        chk(wrap_err == 0, "R3 wrap pulse", wrap_err, 0);
        wr(8'h04, 32'h00);

        // R4 compare readback
        for (int i = 0; i < 8; i++) wr(8'(8'h60 + 4 * i), 32'hA000_0000 + i);
        for (int i = 0; i < 8; i++) begin
            rd(8'(8'h60 + 4 * i), rv);
            chk(rv == 32'hA000_0000 + i, "R4 compare readback", rv, 32'hA000_0000 + i);
        end

        // R2 load and step
        wr(8'h00, 32'h500);
        rd(8'h00, rv); chk(rv == 32'h500, "R2 load", rv, 32'h500);
        repeat (3) @(negedge clk);
        rd(8'h00, rv); chk(rv == 32'h503, "R2 step", rv, 32'h503);

        // R5 vector table
        for (int v = 0; v < 6; v++) begin
            logic [2:0]  ch;
            logic [31:0] st, dl;
            ch = VEC[v][66:64]; st = VEC[v][63:32]; dl = VEC[v][31:0];
            wr(8'h04, 32'(1) << ch);
            wr(8'h08, 32'hFF);
            wr(8'(8'h60 + 4 * ch), st + dl);
            rd(8'h0C, rv); chk(rv[ch] == 1'b1, "R10 armed after write", rv, 32'(1) << ch);
            wr(8'h00, st);
            watch(int'(dl) + 3, st);
            chk(hit_cnt == 1, "R5 single fire", hit_cnt, 1);
            chk(hit_pos == int'(dl), "R5 fire cycle", hit_pos, dl);
            chk(hit_val == 8'(1 << ch), "R5 fire channel", hit_val, 32'(1) << ch);
            chk(irq_err == 0, "R11 irq follows hit", irq_err, 0);
            chk(wrap_err == 0, "R3 wrap pulse", wrap_err, 0);
            rd(8'h08, rv); chk(rv == 32'(1) << ch, "R9 hit flag", rv, 32'(1) << ch);
            rd(8'h0C, rv); chk(rv[ch] == 1'b0, "R10 spent not armed", rv[ch], 0);
        end

        // R6 spent channel 6 silent on a second pass
        wr(8'h08, 32'hFF);
        wr(8'h00, 32'd0);
        watch(203, 32'd0);
        chk(hit_cnt == 0, "R6 no refire", hit_cnt, 0);
        rd(8'h08, rv); chk(rv == 0, "R6 no flag", rv, 0);

        // R7 rewrite re-arms
        wr(8'h78, 32'd200);
        wr(8'h00, 32'd0);
        watch(203, 32'd0);
        chk(hit_cnt == 1 && hit_pos == 200, "R7 re-armed fire", hit_pos, 200);

        // R8 disabled match ignored, stays armed, fires once enabled
        wr(8'h04, 32'h00);
        wr(8'h08, 32'hFF);
        wr(8'h64, 32'd1020);
        wr(8'h00, 32'd1000);
        watch(25, 32'd1000);
        chk(hit_cnt == 0, "R8 disabled silent", hit_cnt, 0);
        rd(8'h0C, rv); chk(rv[1] == 1'b1, "R8 still armed", rv, 32'h2);
        wr(8'h04, 32'h02);
        wr(8'h00, 32'd1000);
        watch(25, 32'd1000);
        chk(hit_cnt == 1 && hit_pos == 20, "R8 fires when enabled", hit_pos, 20);

        // R9 write-0 keeps, write-1 clears
        wr(8'h08, 32'h00);
        rd(8'h08, rv); chk(rv == 32'h2, "R9 write 0 keeps", rv, 32'h2);
        wr(8'h08, 32'h02);
        rd(8'h08, rv); chk(rv == 32'h0, "R9 write 1 clears", rv, 0);

        // R11 two channels, equal targets
        wr(8'h04, 32'h18);
        wr(8'h6C, 32'd50);
        wr(8'h70, 32'd50);
        wr(8'h00, 32'd0);
        watch(53, 32'd0);
        chk(hit_cnt == 1 && hit_pos == 50, "R11 same cycle", hit_pos, 50);
        chk(hit_val == 8'h18, "R11 both channels", hit_val, 32'h18);
        chk(irq_err == 0, "R11 irq follows hit", irq_err, 0);
        rd(8'h08, rv); chk(rv == 32'h18, "R11 both flags", rv, 32'h18);

        // R12 load onto the target
        wr(8'h04, 32'h01);
        wr(8'h60, 32'h777);
        wr(8'h00, 32'h777);
        #1;
        chk(evt_hit == 8'h01 && cmp_irq, "R12 fire on load", evt_hit, 1);
        @(negedge clk); #1;
        chk(evt_hit == 8'h00, "R12 one cycle", evt_hit, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule